// File: doc/BRIEF.md
# Two-Instruction I/O Transfer Sequencer

This block is a very small processor that moves bytes between I/O addresses under the control of a program in ROM. After a qualified reset it fetches from ROM address zero. It has one data register. An input instruction loads the register from an I/O address. An output instruction drives the register onto the bus at an I/O address. A halt instruction stops fetching until the next reset. Each transfer instruction is an opcode byte followed by an address byte. The I/O access is a single clock with an active-low read or write strobe.

The reset input is filtered. It takes effect only after it has been seen low on four consecutive clock edges, so shorter glitches leave the processor as it was. A built-in decoder splits the I/O space into fixed windows and drives one active-low device select per window during the strobe cycle. An access outside every window still runs the full strobe cycle. Such a write is lost. Such a read returns 0xFF, because no device is enabled to drive the bus.

Top module: `postbox_cpu`

## Requirements
- R1: Reset is honoured only after `rst_n` has been low on 4 consecutive rising edges. A low pulse of 3 or fewer edges leaves the state unchanged, including `halted`, `rom_addr` and the register. A qualified reset clears the register to 0x00.
- R2: In the first cycle after a qualified reset is released, `rom_addr` is 0, `halted` is 0, both strobes are high and all device selects are high.
- R3: Opcode 0x01 is an input. The next ROM byte is the I/O address. In the third cycle of the instruction, `io_rd_n` is low for exactly one clock with `io_addr` equal to that byte. The register takes `io_rdata` on the edge that ends the strobe.
- R4: Opcode 0x02 is an output. In the third cycle of the instruction, `io_wr_n` is low for exactly one clock, with `io_addr` equal to the address byte and `io_wdata` equal to the register.
- R5: Opcode 0xFF, or any opcode other than 0x01 and 0x02, halts the processor. `halted` goes high one cycle after the opcode is presented. `rom_addr` then stays at the halt opcode's address, and no strobe occurs until a qualified reset.
- R6: An access to an address that no window decodes still drives a one-cycle strobe with the address on `io_addr`, while every device select stays high.
- R7: `dev_sel_n[k]` is low only during a strobe cycle, and only when `io_addr / 4 == k` for k < 4 (addresses 0x00 to 0x0F). At most one select is low at a time.
- R8: An input from an undecoded address loads 0xFF into the register, whatever `io_rdata` carries.
- R9: `io_rd_n` and `io_wr_n` are never low together, and neither is ever low on two consecutive cycles.
- R10: Instructions run back to back with no idle cycles, one every 3 clocks. Strobe i (counted from 0) falls in cycle 3i+2 after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, qualified by hold time |
| rom_addr | output | ROM_AW | ROM fetch address |
| rom_data | input | 8 | ROM byte at `rom_addr`, valid in the same cycle |
| io_addr | output | 8 | I/O address |
| io_wdata | output | DW | Register value driven for writes |
| io_rdata | input | DW | Data bus driven by the device during reads |
| io_rd_n | output | 1 | Active-low read strobe |
| io_wr_n | output | 1 | Active-low write strobe |
| dev_sel_n | output | NUM_DEV | Active-low device selects from the decoder |
| halted | output | 1 | High while the processor is stopped |

## Verification
The assertions assume three things about the inputs. `rom_data` settles combinationally from `rom_addr` within a cycle. `io_rdata` is stable across the strobe cycle. Every check is gated off until the first qualified reset and is held off while that reset is in force. The bench keeps within these limits. Its ROM is an array indexed directly by `rom_addr`. Device read data is a fixed function of `io_addr` that changes only between programs. Every `rst_n` change is made at a falling clock edge and lasts whole cycles.

// File: rtl/postbox_cpu.sv
module postbox_cpu #(
  parameter int ROM_AW   = 8,
  parameter int DW       = 8,
  parameter int RST_HOLD = 4,
  parameter int NUM_DEV  = 4,
  parameter int DEV_SPAN = 4,
  parameter logic [7:0] OP_IN  = 8'h01,
  parameter logic [7:0] OP_OUT = 8'h02
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [ROM_AW-1:0]  rom_addr,
  input  logic [7:0]         rom_data,
  output logic [7:0]         io_addr,
  output logic [DW-1:0]      io_wdata,
  input  logic [DW-1:0]      io_rdata,
  output logic               io_rd_n,
  output logic               io_wr_n,
  output logic [NUM_DEV-1:0] dev_sel_n,
  output logic               halted
);
  localparam int SPAN_W = $clog2(DEV_SPAN);
  localparam int IDX_W  = 8 - SPAN_W;

  typedef enum logic [1:0] {S_OP, S_ADR, S_IO, S_HLT} st_t;

  st_t                 st;
  logic [ROM_AW-1:0]   pc;
  logic [DW-1:0]       acc;
  logic [7:0]          addr_q;
  logic                is_out;
  logic [RST_HOLD-1:0] rst_hist;
  logic                core_rst;
  logic                strobe;
  logic                hit;
  logic                op_xfer;

  always_ff @(posedge clk)
    rst_hist <= {rst_hist[RST_HOLD-2:0], rst_n};

  assign core_rst = ~|rst_hist;
  assign strobe   = (st == S_IO);
  assign op_xfer  = (rom_data == OP_IN) || (rom_data == OP_OUT);

  always_ff @(posedge clk) begin
    if (core_rst) begin
      st     <= S_OP;
      pc     <= '0;
      acc    <= '0;
      addr_q <= '0;
      is_out <= 1'b0;
    end else begin
      case (st)
        S_OP: begin
          if (op_xfer) begin
            is_out <= (rom_data == OP_OUT);
            pc     <= pc + 1'b1;
            st     <= S_ADR;
          end else begin
            st <= S_HLT;
          end
        end
        S_ADR: begin
          addr_q <= rom_data;
          pc     <= pc + 1'b1;
          st     <= S_IO;
        end
        S_IO: begin
          if (!is_out) acc <= hit ? io_rdata : '1;
          st <= S_OP;
        end
        default: st <= S_HLT;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_dec
    assign dev_sel_n[k] = !(strobe && addr_q[7:SPAN_W] == IDX_W'(k));
  end

  assign hit      = ~&dev_sel_n;
  assign io_rd_n  = !(strobe && !is_out);
  assign io_wr_n  = !(strobe && is_out);
  assign io_addr  = addr_q;
  assign io_wdata = acc;
  assign rom_addr = pc;
  assign halted   = (st == S_HLT);
endmodule

module postbox_cpu_chk #(
  parameter int ROM_AW  = 8,
  parameter int NUM_DEV = 4
) (
  input logic               clk,
  input logic               core_rst,
  input logic               io_rd_n,
  input logic               io_wr_n,
  input logic [NUM_DEV-1:0] dev_sel_n,
  input logic               halted,
  input logic [ROM_AW-1:0]  rom_addr
);
  logic seen_rst = 1'b0;
  always_ff @(posedge clk) seen_rst <= seen_rst | core_rst;

  assert_start_R2: assert property (@(posedge clk)
    (seen_rst && $past(core_rst) && !core_rst) |-> (rom_addr == '0 && !halted && io_rd_n && io_wr_n));
  assert_excl_R9: assert property (@(posedge clk) disable iff (core_rst || !seen_rst)
    !(!io_rd_n && !io_wr_n));
  assert_rd_one_R9: assert property (@(posedge clk) disable iff (core_rst || !seen_rst)
    !io_rd_n |=> io_rd_n);
  assert_wr_one_R9: assert property (@(posedge clk) disable iff (core_rst || !seen_rst)
    !io_wr_n |=> io_wr_n);
  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (core_rst || !seen_rst)
    $onehot0(~dev_sel_n));
  assert_sel_strobe_R7: assert property (@(posedge clk) disable iff (core_rst || !seen_rst)
    (dev_sel_n != '1) |-> (!io_rd_n || !io_wr_n));
  assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (core_rst || !seen_rst)
    halted |=> (halted && $stable(rom_addr)));
  assert_halt_quiet_R5: assert property (@(posedge clk) disable iff (core_rst || !seen_rst)
    halted |-> (io_rd_n && io_wr_n));
endmodule

bind postbox_cpu postbox_cpu_chk #(.ROM_AW(ROM_AW), .NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .core_rst(core_rst), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
  .dev_sel_n(dev_sel_n), .halted(halted), .rom_addr(rom_addr)
);

// File: tb/test_postbox_cpu.sv
module test_postbox_cpu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rom_addr, io_addr, io_wdata, io_rdata, rom_data;
  logic io_rd_n, io_wr_n, halted;
  logic [3:0] dev_sel_n;
  logic [7:0] rom [256];
  logic [7:0] salt = 8'h5A;
  int total = 0, bad = 0, cyc = 0;

  int n_ins;
  bit ev_out [16];
  logic [7:0] ev_addr [16];
  logic [7:0] ev_data [16];
  bit ev_undec [16];

  always #2.5 clk = ~clk;

  assign rom_data = rom[rom_addr];
  assign io_rdata = dev_val(io_addr);

  postbox_cpu i_postbox_cpu (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .dev_sel_n(dev_sel_n), .halted(halted)
  );

  function automatic logic [7:0] dev_val(input logic [7:0] a);
    return (a * 8'd29) ^ salt;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic qual_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic load(input int n, input bit [15:0] kinds, input logic [7:0] adr [16], input logic [7:0] hop);
    logic [7:0] acc = 8'h00;
    bit undec = 1'b0;
    n_ins = n;
    for (int i = 0; i < n; i++) begin
      ev_out[i]  = kinds[i];
      ev_addr[i] = adr[i];
      rom[2*i]   = kinds[i] ? 8'h02 : 8'h01;
      rom[2*i+1] = adr[i];
      if (kinds[i]) begin
        ev_data[i]  = acc;
        ev_undec[i] = undec;
      end else begin
        undec = (adr[i] >= 8'h10);
        acc   = undec ? 8'hFF : dev_val(adr[i]);
        ev_data[i]  = acc;
        ev_undec[i] = 1'b0;
      end
    end
    rom[2*n] = hop;
  endtask

  task automatic run_check();
    for (int c = 0; c <= 3*n_ins + 4; c++) begin
      bit exp_rd = 1'b1, exp_wr = 1'b1;
      logic [3:0] exp_sel = 4'hF;
      @(posedge clk);
      @(negedge clk);
      if (c == 0) chk(rom_addr == 8'h00 && !halted, "R2", "start rom_addr/halted", {rom_addr, 7'b0, halted}, 0);
      if (c < 3*n_ins && c % 3 == 2) begin
        int i = c / 3;
        if (ev_out[i]) exp_wr = 1'b0; else exp_rd = 1'b0;
        if (ev_addr[i] < 8'h10) exp_sel[ev_addr[i] >> 2] = 1'b0;
        chk(io_addr == ev_addr[i], ev_out[i] ? "R4" : "R3", "io_addr", io_addr, ev_addr[i]);
        if (ev_out[i])
          chk(io_wdata == ev_data[i], ev_undec[i] ? "R8" : "R4", "io_wdata", io_wdata, ev_data[i]);
        if (ev_addr[i] >= 8'h10)
          chk(dev_sel_n == 4'hF, "R6", "undecoded select", dev_sel_n, 4'hF);
      end
      chk(io_rd_n == exp_rd && io_wr_n == exp_wr, "R10", "strobe timing", {io_rd_n, io_wr_n}, {exp_rd, exp_wr});
      chk(dev_sel_n == exp_sel, "R7", "device select", dev_sel_n, exp_sel);
      chk(halted == (c >= 3*n_ins + 1), "R5", "halted", halted, c >= 3*n_ins + 1);
      if (c >= 3*n_ins + 1)
        chk(rom_addr == 8'(2*n_ins), "R5", "frozen rom_addr", rom_addr, 2*n_ins);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] adr [16];
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) rom[i] = 8'hFF;

    adr[0] = 8'h00; adr[1] = 8'h40; adr[2] = 8'h03;
    load(3, 16'b101, adr, 8'h00);
    qual_reset();
    @(negedge clk);
    chk(io_rd_n && io_wr_n && dev_sel_n == 4'hF, "R2", "idle bus after reset", {io_rd_n, io_wr_n, dev_sel_n}, 6'h3F);
    load(3, 16'b101, adr, 8'h00);
    qual_reset();
    run_check();

    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(halted && rom_addr == 8'd6, "R1", "short reset ignored", {halted, rom_addr}, {1'b1, 8'd6});

    salt = 8'hC3;
    adr[0] = 8'h05; adr[1] = 8'h09; adr[2] = 8'h99; adr[3] = 8'h0F;
    load(4, 16'b1101, adr, 8'hFF);
    qual_reset();
    run_check();

    for (int p = 0; p < 24; p++) begin
      int n = 1 + ($urandom % 12);
      bit [15:0] kinds = 16'($urandom);
      logic [7:0] hop;
      for (int i = 0; i < n; i++) adr[i] = 8'($urandom % 48);
      do hop = 8'($urandom); while (hop == 8'h01 || hop == 8'h02);
      if (p % 4 == 0) hop = 8'hFF;
      salt = 8'($urandom);
      load(n, kinds, adr, hop);
      qual_reset();
      run_check();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule